// File: doc/BRIEF.md
# Pin Change Wake and Interrupt Controller

This block watches a vector of up to 23 input pins and raises a sticky interrupt request when any pin whose enable bit is set moves to a level different from its stored reference level. Either direction counts. The same comparison also runs with no clock. While the sleep input is high, a mismatch on an enabled pin sets a wake flag at once. That flag tells the clock controller to restart the clock. Once clocks run again and sleep is released, the flag becomes an interrupt.

The block also holds per-pin pull-up and pull-down selections and drives them to the pad controls. It never drives both pulls on one pin: the pull-up wins and a conflict status bit records the clash. Both pulls are forced off on any pin that the pad direction input marks as a digital output. Software reaches all of this through a small register bus. Writes take effect on the next clock edge. Read data is registered.

Top module: `cn_notify`

## Requirements
- R1: After synchronous reset, irq_o, wake_o, pu_en_o and pd_en_o are all zero, and every register reads zero.
- R2: Address 0 holds interrupt enables for pins 0 to 15 in data bits 15:0. Address 1 holds enables for pins 16 to 22 in bits 6:0, and its upper bits read as zero. bus_rdata shows the register at bus_addr one clock edge later.
- R3: While awake, a rising or a falling change on an enabled pin sets irq_o within four clock cycles.
- R4: A change on a disabled pin never sets irq_o. While a pin is disabled its reference follows the pin, so enabling a pin that already sits high raises no request.
- R5: irq_o stays set until a clear. A clear is either a one-cycle pulse on irq_clr_i or a write of 1 to bit 0 of address 6; writing 0 there does nothing. A clear reloads every reference from the pins, so a pin that stays at its new level does not raise the request again.
- R6: With sleep_i high and the clock stopped, a change on an enabled pin sets wake_o with no clock edge. wake_o holds even if the pin returns. A disabled pin leaves wake_o low.
- R7: After clocks resume and sleep_i goes low, a pending wake sets irq_o and drops wake_o within four cycles. irq_o stays low while sleep_i is high.
- R8: Pull-up enables are at addresses 2 (pins 0-15) and 3 (pins 16-22). Pull-down enables are at 4 and 5, with the same bit layout. pu_en_o[i] is the pull-up bit with pin_dir_out_i[i] clear, registered once.
- R9: pd_en_o[i] is the pull-down bit with neither the pull-up bit nor pin_dir_out_i[i] set. Address 7 (pins 0-15) and address 8 (pins 16-22) read a conflict bit that is 1 where both pull bits are set.
- R10: Address 6 reads irq_o in bit 0 and wake_o in bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; may stop while asleep |
| rst | input | 1 | Synchronous active-high reset |
| sleep_i | input | 1 | High while the system is asleep |
| pin_i | input | 23 | Raw pin levels, asynchronous |
| pin_dir_out_i | input | 23 | 1 where the pin is a digital output |
| irq_clr_i | input | 1 | One-cycle interrupt clear pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Registered read data |
| irq_o | output | 1 | Sticky interrupt request |
| wake_o | output | 1 | Asynchronously set wake request |
| pu_en_o | output | 23 | Pad pull-up enables |
| pd_en_o | output | 23 | Pad pull-down enables |

## Verification
The bench aims at the pulse that comes and goes while the clock is stopped. A design that only compared synchronized levels would miss it and never interrupt after wake-up. It also checks that enabling a pin that already sits high stays quiet, and that a pin held at its new level after a clear does not fire again; a reference that fails to track or reload would raise spurious requests. It sets both pulls on one pin, and drives pins as outputs, to catch a pad that gets both pulls or a pull on a driven pin. It also checks that pin 22 and pin 16 in the upper register are reached, which exposes an off-by-one split between the two enable registers.

// File: rtl/cn_pkg.sv
package cn_pkg;
  // Register map; offsets are decoded by the register file and the bench.
  localparam int unsigned ADR_IEN_LO  = 0;
  localparam int unsigned ADR_IEN_HI  = 1;
  localparam int unsigned ADR_PU_LO   = 2;
  localparam int unsigned ADR_PU_HI   = 3;
  localparam int unsigned ADR_PD_LO   = 4;
  localparam int unsigned ADR_PD_HI   = 5;
  localparam int unsigned ADR_STAT    = 6;
  localparam int unsigned ADR_CONF_LO = 7;
  localparam int unsigned ADR_CONF_HI = 8;
  localparam int unsigned STAT_IRQ_BIT  = 0;
  localparam int unsigned STAT_WAKE_BIT = 1;
endpackage

// File: rtl/cn_regs.sv
module cn_regs
  import cn_pkg::*;
#(
  parameter int unsigned N  = 23,
  parameter int unsigned BW = 16,
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] wdata,
  input  logic          irq,
  input  logic          wake,
  input  logic [N-1:0]  conf,
  output logic [N-1:0]  ien,
  output logic [N-1:0]  pu,
  output logic [N-1:0]  pd,
  output logic          stat_clr,
  output logic [BW-1:0] rdata
);
  localparam int unsigned HW = N - BW;

  logic [N-1:0]  ien_q, pu_q, pd_q;
  logic [BW-1:0] rd_mux;

  function automatic logic [BW-1:0] hi_part(input logic [N-1:0] v);
    return BW'(v[N-1:BW]);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q <= '0;
      pu_q  <= '0;
      pd_q  <= '0;
    end else if (wr) begin
      case (32'(addr))
        ADR_IEN_LO: ien_q[BW-1:0] <= wdata;
        ADR_IEN_HI: ien_q[N-1:BW] <= wdata[HW-1:0];
        ADR_PU_LO:  pu_q[BW-1:0]  <= wdata;
        ADR_PU_HI:  pu_q[N-1:BW]  <= wdata[HW-1:0];
        ADR_PD_LO:  pd_q[BW-1:0]  <= wdata;
        ADR_PD_HI:  pd_q[N-1:BW]  <= wdata[HW-1:0];
        default: ;
      endcase
    end
  end

  assign stat_clr = wr && (32'(addr) == ADR_STAT) && wdata[STAT_IRQ_BIT];

  always_comb begin
    rd_mux = '0;
    case (32'(addr))
      ADR_IEN_LO:  rd_mux = ien_q[BW-1:0];
      ADR_IEN_HI:  rd_mux = hi_part(ien_q);
      ADR_PU_LO:   rd_mux = pu_q[BW-1:0];
      ADR_PU_HI:   rd_mux = hi_part(pu_q);
      ADR_PD_LO:   rd_mux = pd_q[BW-1:0];
      ADR_PD_HI:   rd_mux = hi_part(pd_q);
      ADR_STAT: begin
        rd_mux[STAT_IRQ_BIT]  = irq;
        rd_mux[STAT_WAKE_BIT] = wake;
      end
      ADR_CONF_LO: rd_mux = conf[BW-1:0];
      ADR_CONF_HI: rd_mux = hi_part(conf);
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  assign ien = ien_q;
  assign pu  = pu_q;
  assign pd  = pd_q;
endmodule

// File: rtl/cn_detect.sv
module cn_detect #(
  parameter int unsigned N    = 23,
  parameter int unsigned SYNC = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sleep_i,
  input  logic [N-1:0] pin_i,
  input  logic [N-1:0] ien,
  input  logic         clr,
  output logic         irq_o,
  output logic         wake_o
);
  logic [N-1:0]    sync_q [SYNC];
  logic [N-1:0]    pin_s, ref_q;
  logic [SYNC-1:0] wk_s;
  logic            clr_ok, hit, async_hit, wake_q, wake_take, irq_q;

  // Pin synchronizer chain
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SYNC; s++) sync_q[s] <= '0;
    end else begin
      sync_q[0] <= pin_i;
      for (int s = 1; s < SYNC; s++) sync_q[s] <= sync_q[s-1];
    end
  end
  assign pin_s = sync_q[SYNC-1];

  assign clr_ok = clr & ~sleep_i;

  // Reference: tracks disabled pins, holds enabled ones, reloads on clear
  always_ff @(posedge clk) begin
    if (rst)         ref_q <= '0;
    else if (clr_ok) ref_q <= pin_s;
    else             ref_q <= (ref_q & ien) | (pin_s & ~ien);
  end

  assign hit       = ~sleep_i & (|(ien & (pin_s ^ ref_q)));
  assign async_hit = sleep_i & (|(ien & (pin_i ^ ref_q)));

  // Wake flag: set without a clock, cleared once handed to the clock domain
  always_ff @(posedge clk or posedge async_hit) begin
    if (async_hit)            wake_q <= 1'b1;
    else if (rst | wake_take) wake_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst | wake_take) wk_s <= '0;
    else                 wk_s <= {wk_s[SYNC-2:0], wake_q};
  end
  assign wake_take = wk_s[SYNC-1] & ~sleep_i;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= (irq_q & ~clr_ok) | wake_take | (hit & ~clr_ok);
  end

  assign irq_o  = irq_q;
  assign wake_o = wake_q;
endmodule

// File: rtl/cn_pull.sv
module cn_pull #(
  parameter int unsigned N = 23
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pu,
  input  logic [N-1:0] pd,
  input  logic [N-1:0] dir_out,
  output logic [N-1:0] pu_en_o,
  output logic [N-1:0] pd_en_o,
  output logic [N-1:0] conf_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pu_en_o <= '0;
      pd_en_o <= '0;
      conf_o  <= '0;
    end else begin
      pu_en_o <= pu & ~dir_out;
      pd_en_o <= pd & ~pu & ~dir_out;
      conf_o  <= pu & pd;
    end
  end
endmodule

// File: rtl/cn_notify.sv
module cn_notify #(
  parameter int unsigned NUM_PINS = 23,
  parameter int unsigned BUS_W    = 16,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned SYNC     = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sleep_i,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] pin_dir_out_i,
  input  logic                irq_clr_i,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  output logic                irq_o,
  output logic                wake_o,
  output logic [NUM_PINS-1:0] pu_en_o,
  output logic [NUM_PINS-1:0] pd_en_o
);
  logic [NUM_PINS-1:0] ien, pu, pd, conf;
  logic                stat_clr;

  cn_regs #(.N(NUM_PINS), .BW(BUS_W), .AW(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .irq(irq_o), .wake(wake_o), .conf(conf),
    .ien(ien), .pu(pu), .pd(pd), .stat_clr(stat_clr), .rdata(bus_rdata)
  );

  cn_detect #(.N(NUM_PINS), .SYNC(SYNC)) u_detect (
    .clk(clk), .rst(rst), .sleep_i(sleep_i), .pin_i(pin_i), .ien(ien),
    .clr(irq_clr_i | stat_clr), .irq_o(irq_o), .wake_o(wake_o)
  );

  cn_pull #(.N(NUM_PINS)) u_pull (
    .clk(clk), .rst(rst), .pu(pu), .pd(pd), .dir_out(pin_dir_out_i),
    .pu_en_o(pu_en_o), .pd_en_o(pd_en_o), .conf_o(conf)
  );
endmodule

// File: rtl/cn_notify_chk.sv
module cn_notify_chk
  import cn_pkg::*;
#(
  parameter int unsigned N  = 23,
  parameter int unsigned AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          sleep_i,
  input logic [N-1:0]  pin_dir_out_i,
  input logic          irq_clr_i,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wdata0,
  input logic          irq_o,
  input logic          wake_o,
  input logic [N-1:0]  pu_en_o,
  input logic [N-1:0]  pd_en_o
);
  logic clr_req;
  assign clr_req = irq_clr_i | (bus_wr && (32'(bus_addr) == ADR_STAT) && bus_wdata0);

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!irq_o && pu_en_o == '0 && pd_en_o == '0));

  // R9
  a_r9_pull_exclusive: assert property (@(posedge clk) disable iff (rst)
    (pu_en_o & pd_en_o) == '0);

  // R8
  a_r8_out_no_pull: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pu_en_o | pd_en_o) & $past(pin_dir_out_i)) == '0);

  // R5
  a_r5_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !clr_req) |=> irq_o);

  // R6
  a_r6_wake_hold: assert property (@(posedge clk) disable iff (rst)
    (wake_o && sleep_i) |=> wake_o);
endmodule

bind cn_notify cn_notify_chk #(.N(NUM_PINS), .AW(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .sleep_i(sleep_i), .pin_dir_out_i(pin_dir_out_i),
  .irq_clr_i(irq_clr_i), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata0(bus_wdata[0]), .irq_o(irq_o), .wake_o(wake_o),
  .pu_en_o(pu_en_o), .pd_en_o(pd_en_o)
);

// File: tb/test_cn_notify.sv
module test_cn_notify;
  localparam int N  = 23;
  localparam int BW = 16;

  logic          clk = 1'b0, clk_run = 1'b1, rst = 1'b1, sleep_i = 1'b0;
  logic [N-1:0]  pin_i = '0, pin_dir_out_i = '0;
  logic          irq_clr_i = 1'b0, bus_wr = 1'b0;
  logic [3:0]    bus_addr = '0;
  logic [BW-1:0] bus_wdata = '0;
  logic [BW-1:0] bus_rdata;
  logic          irq_o, wake_o;
  logic [N-1:0]  pu_en_o, pd_en_o;
  int checks = 0, fails = 0;
  logic [BW-1:0] rd;

  cn_notify i_cn_notify (
    .clk(clk), .rst(rst), .sleep_i(sleep_i), .pin_i(pin_i),
    .pin_dir_out_i(pin_dir_out_i), .irq_clr_i(irq_clr_i), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .wake_o(wake_o), .pu_en_o(pu_en_o), .pd_en_o(pd_en_o)
  );

  always #2 clk = clk_run ? ~clk : clk;

  // {enable mask, pin pattern, expected irq}
  localparam logic [46:0] VEC [7] = '{
    {23'h000001, 23'h000001, 1'b1},
    {23'h000001, 23'h000002, 1'b0},
    {23'h400000, 23'h400000, 1'b1},
    {23'h7FFFFF, 23'h000000, 1'b0},
    {23'h00FF00, 23'h0000FF, 1'b0},
    {23'h010000, 23'h010000, 1'b1},
    {23'h008000, 23'h7F8000, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [BW-1:0] d);
    bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rdreg(input int a, output logic [BW-1:0] d);
    bus_addr = 4'(a);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic set_ien(input logic [N-1:0] v);
    wr(0, v[15:0]);
    wr(1, BW'(v[22:16]));
  endtask

  task automatic pulse_clr;
    irq_clr_i = 1'b1;
    @(negedge clk);
    irq_clr_i = 1'b0;
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 wake", 32'(wake_o), 0);
    chk("R1 pulls", 32'(pu_en_o | pd_en_o), 0);
    rdreg(0, rd); chk("R1 ien lo", 32'(rd), 0);
    rdreg(6, rd); chk("R1 status", 32'(rd), 0);

    // R2 register split and read-back
    wr(1, 16'hFFFF);
    rdreg(1, rd); chk("R2 ien hi upper bits", 32'(rd), 32'h7F);
    wr(0, 16'hA5C3);
    rdreg(0, rd); chk("R2 ien lo", 32'(rd), 32'hA5C3);
    set_ien('0);
    tick(4); pulse_clr();

    // R3/R4 table walk
    for (int k = 0; k < 7; k++) begin
      logic [N-1:0] en, pv;
      logic ex;
      {en, pv, ex} = VEC[k];
      pin_i = '0;
      set_ien(en);
      tick(4); pulse_clr(); tick(1);
      pin_i = pv;
      tick(5);
      chk(ex ? "R3 enabled change" : "R4 disabled change", 32'(irq_o), 32'(ex));
      pin_i = '0;
      tick(5);
      set_ien('0);
      pulse_clr(); tick(2);
    end

    // R3 falling edge
    pin_i = 23'h000010;
    tick(4);
    // R4 enabling a high pin is quiet
    set_ien(23'h000010);
    tick(5);
    chk("R4 enable captures level", 32'(irq_o), 0);
    pin_i = '0;
    tick(5);
    chk("R3 falling edge", 32'(irq_o), 1);
    rdreg(6, rd); chk("R10 status irq bit", 32'(rd), 1);

    // R5 write of 0 does not clear; write of 1 clears and reloads
    wr(6, 16'h0000); tick(2);
    chk("R5 status write 0 ignored", 32'(irq_o), 1);
    wr(6, 16'h0001); tick(5);
    chk("R5 status write clears, low level held", 32'(irq_o), 0);
    pin_i = 23'h000010; tick(5);
    chk("R5 sticky after rise", 32'(irq_o), 1);
    pulse_clr(); tick(6);
    chk("R5 pulse clear, new level held", 32'(irq_o), 0);
    pin_i = '0; tick(5); pulse_clr(); tick(2);

    // R6/R7 sleep with the clock stopped
    set_ien(23'h000008);
    tick(4); pulse_clr(); tick(2);
    sleep_i = 1'b1;
    tick(1);
    clk_run = 1'b0;
    #10;
    pin_i = 23'h000020; #3; pin_i = '0; #3;
    chk("R6 disabled pin no wake", 32'(wake_o), 0);
    pin_i = 23'h000008; #1;
    chk("R6 async wake set", 32'(wake_o), 1);
    pin_i = '0; #5;
    chk("R6 wake held after pulse", 32'(wake_o), 1);
    clk_run = 1'b1;
    tick(4);
    chk("R7 no irq while asleep", 32'(irq_o), 0);
    rdreg(6, rd); chk("R10 status wake bit", 32'(rd), 32'h2);
    sleep_i = 1'b0;
    tick(4);
    chk("R7 irq after wake", 32'(irq_o), 1);
    chk("R7 wake dropped", 32'(wake_o), 0);
    pulse_clr(); tick(3);
    chk("R7 cleared, pin back at reference", 32'(irq_o), 0);
    set_ien('0);

    // R8/R9 pulls
    pin_dir_out_i = 23'h000001;
    wr(2, 16'h0003);
    wr(4, 16'h0006);
    tick(2);
    chk("R8 pull-up gated by output", 32'(pu_en_o), 32'h2);
    chk("R9 pull-down gated", 32'(pd_en_o), 32'h4);
    rdreg(7, rd); chk("R9 conflict lo", 32'(rd), 32'h2);
    wr(3, 16'h0041);
    wr(5, 16'h0003);
    pin_dir_out_i = 23'h400000;
    tick(2);
    chk("R8 pull-up hi", 32'(pu_en_o), 32'h010003);
    chk("R9 pull-down hi", 32'(pd_en_o), 32'h020004);
    rdreg(8, rd); chk("R9 conflict hi", 32'(rd), 32'h1);
    rdreg(3, rd); chk("R8 pu hi readback", 32'(rd), 32'h41);

    finish_run();
  end
endmodule